// File: doc/BRIEF.md
# Edge-Triggered Interrupt Latch Controller

This block merges up to three interrupt sources into one sticky interrupt request. The sources are bit 3 of digital port C, a general external input and output 2 of the first interval timer. Three static strap inputs set the routing. One strap chooses whether the digital path watches port C bit 3 or the external input. A second strap turns the digital path on, and a third turns the timer path on. Each source is brought into the system clock domain and edge-detected there. A rising edge on an enabled path sets a latch, which stays set until software clears it.

Software uses the block's byte-wide register bus. A write to one address arms the request output and a write to another disarms it. A write to a third address clears the latch. The data byte of these writes is ignored. An active-low inhibit pin forces the request output low for as long as it is held low. Software can raise an interrupt by toggling port C bit 3 when that bit is an output.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the request output `irq_o` is 0, interrupts are disarmed and the latch is clear. Arming right after reset leaves `irq_o` at 0.
- R2: With `sel_ext_i`=0 and `dig_en_i`=1, a 0-to-1 transition on `pc3_i` sets the latch. The latch is set in the third rising clock edge after the input changes, counting the two synchroniser flops.
- R3: With `sel_ext_i`=1 and `dig_en_i`=1, a rising edge on `ext_i` sets the latch and `pc3_i` is ignored. With `sel_ext_i`=0, `ext_i` is ignored.
- R4: With `tmr_en_i`=1, a rising edge on `tmr_i` sets the latch.
- R5: An edge on a path whose enable strap is 0 does not set the latch (digital path with `dig_en_i`=0, timer path with `tmr_en_i`=0).
- R6: Only a rising edge sets the latch. A source that stays high, or that falls, does not set it again after a clear.
- R7: Once set, the latch stays set after its source returns low, until it is cleared.
- R8: A write (`wr_i`=1) to address 0xE arms the output and a write to 0xD disarms it, whatever the data. `irq_o` is the latch gated by the armed state. Edges that arrive while disarmed still set the latch.
- R9: A write to address 0xF clears the latch, whatever the data.
- R10: If a clear write and a new rising edge are taken on the same clock edge, the latch stays set.
- R11: While `inhibit_ni` is 0, `irq_o` is 0. The latch and the armed state are kept, and `irq_o` returns when `inhibit_ni` goes back to 1.
- R12: Writes to any other address, and cycles with `wr_i`=0 at any address, leave the armed state and the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data (ignored by this block) |
| sel_ext_i | input | 1 | Strap: 1 selects the external input as the digital source, 0 selects port C bit 3 |
| dig_en_i | input | 1 | Strap: enables the digital path |
| tmr_en_i | input | 1 | Strap: enables the timer path |
| pc3_i | input | 1 | Port C bit 3 source |
| ext_i | input | 1 | External interrupt source |
| tmr_i | input | 1 | Timer output source |
| inhibit_ni | input | 1 | Active-low interrupt inhibit |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. The strap inputs change only while the sources are low and no edge is in flight. Each source pulse lasts at least one clock. The inhibit pin gates the output directly and has no timing tie to the clock. The stimulus meets these by setting the straps while every source is low. It holds each pulse high for four clocks and low for four more before the next pulse. It drives all inputs, including `inhibit_ni`, half a period away from the active edge.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  localparam int NUM_SRC = 3;

  typedef enum int {
    SRC_PC3 = 0,
    SRC_EXT = 1,
    SRC_TMR = 2
  } src_idx_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ARM  = 2'd1,
    CMD_MASK = 2'd2,
    CMD_CLR  = 2'd3
  } irq_cmd_e;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  // R6: a detected edge lasts exactly one cycle
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/irq_cmd_dec.sv
module irq_cmd_dec
  import irq_latch_pkg::*;
#(
  parameter int              ADDR_W   = 5,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] ADR_MASK = ADDR_W'(4'hD),
  parameter logic [ADDR_W-1:0] ADR_ARM  = ADDR_W'(4'hE),
  parameter logic [ADDR_W-1:0] ADR_CLR  = ADDR_W'(4'hF)
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output irq_cmd_e          cmd_o
);

  // strobes are address-only; data is deliberately dropped
  logic data_unused;
  assign data_unused = ^wdata_i;

  always_comb begin
    cmd_o = CMD_NONE;
    if (wr_i) begin
      unique case (addr_i)
        ADR_ARM:  cmd_o = CMD_ARM;
        ADR_MASK: cmd_o = CMD_MASK;
        ADR_CLR:  cmd_o = CMD_CLR;
        default:  cmd_o = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_latch_core.sv
module irq_latch_core
  import irq_latch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_cmd_e cmd_i,
  input  logic     hit_i,
  input  logic     inhibit_ni,
  output logic     irq_o
);

  logic armed_q;
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (cmd_i == CMD_ARM) begin
      armed_q <= 1'b1;
    end else if (cmd_i == CMD_MASK) begin
      armed_q <= 1'b0;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
    end else if (hit_i) begin
      latch_q <= 1'b1;
    end else if (cmd_i == CMD_CLR) begin
      latch_q <= 1'b0;
    end
  end

  assign irq_o = latch_q & armed_q & inhibit_ni;

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> latch_q);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_CLR && !hit_i) |=> !latch_q);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && cmd_i != CMD_CLR) |=> latch_q);

  a_r8_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ARM) |=> armed_q);

  a_r8_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MASK) |=> !irq_o);

  a_r11_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_ni |-> !irq_o);

  a_r12_hold_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NONE) |=> $stable(armed_q));

  a_r12_hold_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NONE && !hit_i) |=> $stable(latch_q));

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sel_ext_i,
  input  logic              dig_en_i,
  input  logic              tmr_en_i,
  input  logic              pc3_i,
  input  logic              ext_i,
  input  logic              tmr_i,
  input  logic              inhibit_ni,
  output logic              irq_o
);

  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_rise;
  logic               dig_rise;
  logic               hit;
  irq_cmd_e           cmd;

  assign src_raw[SRC_PC3] = pc3_i;
  assign src_raw[SRC_EXT] = ext_i;
  assign src_raw[SRC_TMR] = tmr_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (src_raw[g]),
      .rise_o (src_rise[g])
    );
  end

  assign dig_rise = sel_ext_i ? src_rise[SRC_EXT] : src_rise[SRC_PC3];
  assign hit      = (dig_en_i & dig_rise) | (tmr_en_i & src_rise[SRC_TMR]);

  irq_cmd_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  irq_latch_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .hit_i      (hit),
    .inhibit_ni (inhibit_ni),
    .irq_o      (irq_o)
  );

  // R5: paths with enable strap low never produce a hit
  a_r5_no_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dig_en_i && !tmr_en_i) |-> !hit);

endmodule

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MASK = 5'hD;
  localparam logic [4:0] A_ARM  = 5'hE;
  localparam logic [4:0] A_CLR  = 5'hF;

  // {sel_ext, dig_en, tmr_en, pulse pc3, pulse ext, pulse tmr, expected irq}
  localparam int NVEC = 9;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b010_100_1,  // R2 port C bit 3 edge
    7'b010_010_0,  // R3 ext ignored when port C chosen
    7'b110_010_1,  // R3 ext edge
    7'b110_100_0,  // R3 pc3 ignored when ext chosen
    7'b001_001_1,  // R4 timer edge
    7'b110_001_0,  // R5 timer path off
    7'b000_100_0,  // R5 digital path off
    7'b100_010_0,  // R5 digital path off, ext chosen
    7'b011_101_1   // R4 both paths enabled
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       sel_ext = 1'b0, dig_en = 1'b0, tmr_en = 1'b0;
  logic       pc3 = 1'b0, ext = 1'b0, tmr = 1'b0;
  logic       inhibit_n = 1'b1;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_latch_ctrl uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .sel_ext_i  (sel_ext),
    .dig_en_i   (dig_en),
    .tmr_en_i   (tmr_en),
    .pc3_i      (pc3),
    .ext_i      (ext),
    .tmr_i      (tmr),
    .inhibit_ni (inhibit_n),
    .irq_o      (irq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: irq_o=%b expected completion", irq);
    finish_run();
  end

  initial begin
    idle(3);
    check("R1 reset", irq, 1'b0);
    rst_ni = 1'b1;
    idle(2);
    sel_ext = 1'b0; dig_en = 1'b1; tmr_en = 1'b1;
    bus_wr(A_ARM, 8'h00);
    idle(4);
    check("R1 armed after reset", irq, 1'b0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {sel_ext, dig_en, tmr_en} = VEC[i][6:4];
      bus_wr(A_CLR, 8'h00);
      @(negedge clk);
      {pc3, ext, tmr} = VEC[i][3:1];
      idle(4);
      check($sformatf("table row %0d", i), irq, VEC[i][0]);
      pc3 = 1'b0; ext = 1'b0; tmr = 1'b0;
      idle(4);
    end

    sel_ext = 1'b0; dig_en = 1'b1; tmr_en = 1'b0;

    // R7: stays set after source low
    bus_wr(A_CLR, 8'h00);
    @(negedge clk); pc3 = 1'b1;
    idle(4); pc3 = 1'b0;
    idle(10);
    check("R7 sticky", irq, 1'b1);

    // R9: clear with arbitrary data
    bus_wr(A_CLR, 8'hFF);
    idle(1);
    check("R9 clear", irq, 1'b0);

    // R6: steady high after clear, then fall
    @(negedge clk); pc3 = 1'b1;
    idle(5);
    bus_wr(A_CLR, 8'h11);
    idle(5);
    check("R6 steady high", irq, 1'b0);
    pc3 = 1'b0;
    idle(5);
    check("R6 falling edge", irq, 1'b0);

    // R8: disarm / re-arm, data ignored
    @(negedge clk); pc3 = 1'b1;
    idle(4); pc3 = 1'b0;
    idle(4);
    bus_wr(A_MASK, 8'h00);
    check("R8 disarm", irq, 1'b0);
    bus_wr(A_ARM, 8'h5A);
    check("R8 rearm", irq, 1'b1);

    // R8: edge while disarmed is kept
    bus_wr(A_CLR, 8'h00);
    bus_wr(A_MASK, 8'hA5);
    @(negedge clk); pc3 = 1'b1;
    idle(4); pc3 = 1'b0;
    idle(4);
    check("R8 masked edge hidden", irq, 1'b0);
    bus_wr(A_ARM, 8'h00);
    check("R8 masked edge latched", irq, 1'b1);

    // R12: other addresses and wr low
    bus_wr(5'h3, 8'hFF);
    bus_wr(5'hC, 8'h00);
    bus_wr(5'h1F, 8'h00);
    @(negedge clk); wr = 1'b0; addr = A_CLR;
    idle(2); addr = A_MASK;
    idle(2); addr = '0;
    check("R12 no-op accesses", irq, 1'b1);

    // R11: inhibit gates output only
    inhibit_n = 1'b0;
    idle(2);
    check("R11 inhibited", irq, 1'b0);
    inhibit_n = 1'b1;
    idle(1);
    check("R11 released", irq, 1'b1);

    // R10: clear on the same edge as a new rise
    bus_wr(A_CLR, 8'h00);
    idle(1);
    check("R10 precondition clear", irq, 1'b0);
    @(negedge clk); pc3 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = A_CLR;
    @(negedge clk);
    wr = 1'b0; addr = '0;
    check("R10 set wins", irq, 1'b1);
    pc3 = 1'b0;
    idle(4);
    check("R10 held", irq, 1'b1);

    finish_run();
  end

endmodule